// File: doc/BRIEF.md
# Pipelined Bilinear Texel Filter

This block blends four neighbouring texels into one filtered pixel for texture sampling. Two 7-bit fractional coordinates select how far the sample lies between the texels. The block turns them into four non-negative weights that sum to exactly 128. Each weight is held as four signed radix-4 digits, so the datapath forms partial products only by shifting, doubling and negating. No multiplier array exists per product and no digit recoding sits in the per-step path.

One job starts on a single strobe. The strobe cycle carries both fractions and the first texel, and the next three texels follow on consecutive cycles. Every texel packs four 8-bit channels into independent lanes. In each lane the four partial products of one texel pass through a short carry-save chain. The four texels follow one another one stage apart, so several jobs' products share the chain at once. A final adder accumulates them. The rounded pixel appears seven clock edges after the start. A new job may begin in the cycle that follows the last texel of the previous one, which gives one result every four cycles.

Top module: `bilerp_top`

## Requirements
- R1: With fractions a and b read as unsigned values over 128, the weights are w11 = (a·b + 64) >> 7, w10 = a − w11, w01 = b − w11 and w00 = 128 − a − b + w11. Each weight lies in 0..128 and the four always total 128.
- R2: Each weight is coded as four digits of value −2..+2, where digit k carries 4^k. A digit uses 3 bits {neg, one, two}: one and two are never both set, and neg is never set when the magnitude is zero.
- R3: A job starts in a cycle where start is high and no job is in its last three steps. That cycle supplies a, b and the texel for weight w00 on `texel`. The next three cycles supply the texels for w10, w01 and w11, in that order.
- R4: A start strobe during the three cycles that follow an accepted start is ignored. It causes no additional result and leaves the running job's result unchanged.
- R5: `out_valid` is high for exactly one cycle. That cycle follows the seventh rising edge counted from the edge that samples the accepted start, and `out_pix` takes the new value in the same cycle.
- R6: The four lanes (lane k at bits 8k+7..8k) are computed independently. Each lane gives (w00·P1 + w10·P2 + w01·P3 + w11·P4 + 64) >> 7.
- R7: After reset, `out_valid` is 0 and `out_pix` is 0. `out_pix` keeps its last value in every cycle in which `out_valid` is low.
- R8: Jobs started every fourth cycle with no gap each produce their own result, four cycles apart, in start order and without mixing data between jobs.
- R9: With a = b = 0 the output equals the first texel exactly. When all four texels are equal, the output equals that texel for any fractions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a job this cycle (ignored while a job is stepping) |
| frac_a | input | 7 | Horizontal fraction, sampled in the start cycle |
| frac_b | input | 7 | Vertical fraction, sampled in the start cycle |
| texel | input | 32 | Four 8-bit channels of the texel for the current step |
| out_valid | output | 1 | One-cycle strobe marking a new filtered pixel |
| out_pix | output | 32 | Four 8-bit filtered channels, held between results |

## Verification
Two things can happen in the same cycle. The accumulator can close one job while the first partial products of the next job are already in the carry-save chain. A job can also be started in the very cycle after the previous job's last texel. Both cases are provoked by issuing starts every fourth cycle with no gap, with fractions and texels that differ from job to job. Each result is judged by its exact cycle and its exact value against a reference computed from the weight formula, so any leakage of one job's sum into the next shows up as a wrong pixel. A second kind of collision, a start strobe held high while a job is stepping, is judged by requiring exactly one result with the first job's value.

// File: rtl/bilerp_pkg.sv
// Package: shared sizes, digit types and the arithmetic helpers of the
// bilinear filter. The reduction chain in bilerp_lane is sized for four
// digits per weight, which FRAC_W = 7 yields.
package bilerp_pkg;

    localparam int CH_W   = 8;                   // bits per colour channel
    localparam int FRAC_W = 7;                   // fractional coordinate bits
    localparam int NTAPS  = 4;                   // texels per job
    localparam int WT_W   = FRAC_W + 1;          // weight width, range 0..2^FRAC_W
    localparam int NDIG   = WT_W / 2;            // radix-4 digits per weight
    localparam int ONE    = 1 << FRAC_W;         // weight total
    localparam int HALF   = ONE / 2;             // rounding offset
    localparam int ACC_W  = CH_W + WT_W + 2;     // signed partial/accumulator width
    localparam int PIPE_D = NDIG - 1;            // stages between issue and accumulate
    localparam int V_W    = WT_W + 2;            // recoding scratch width

    // One signed radix-4 digit: magnitude one or two, optional negate.
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } bdig_t;

    typedef bdig_t [NDIG-1:0] bweight_t;

    // Recode a non-negative weight into NDIG digits of value -2..+2.
    function automatic bweight_t booth_code(input logic [WT_W-1:0] w);
        bweight_t code;
        logic signed [V_W-1:0] v;
        v = signed'({2'b00, w});
        for (int k = 0; k < NDIG; k++) begin
            code[k] = '0;
            case (v[1:0])
                2'b01: begin code[k].one = 1'b1; v = v - V_W'(1); end
                2'b10: begin code[k].two = 1'b1; v = v - V_W'(2); end
                2'b11: begin code[k].one = 1'b1; code[k].neg = 1'b1; v = v + V_W'(1); end
                default: ;
            endcase
            v = v >>> 2;
        end
        return code;
    endfunction

    // Partial product: texel times digit, placed at radix-4 position pos.
    function automatic logic signed [ACC_W-1:0] pp_form(input logic [CH_W-1:0] p,
                                                        input bdig_t d,
                                                        input int pos);
        logic signed [ACC_W-1:0] m;
        m = '0;
        if (d.one)      m = signed'(ACC_W'(p));
        else if (d.two) m = signed'(ACC_W'({p, 1'b0}));
        m = m <<< (2 * pos);
        if (d.neg) m = -m;
        return m;
    endfunction

    // Integer value of a digit, for checking.
    function automatic int dig_val(input bdig_t d);
        int m;
        m = d.two ? 2 : (d.one ? 1 : 0);
        return d.neg ? -m : m;
    endfunction

endpackage

// File: rtl/bilerp_weights.sv
// Module: derives the four bilinear weights from the two fractions and
// emits them already digit-coded. Purely combinational. Assumes fractions
// are unsigned values over 2^FRAC_W. The only product is a*b; the other
// weights follow by subtraction, so their total is exact.
module bilerp_weights
    import bilerp_pkg::*;
(
    input  logic [FRAC_W-1:0]        frac_a,
    input  logic [FRAC_W-1:0]        frac_b,
    output bweight_t [NTAPS-1:0]     wt_code
);

    logic [2*FRAC_W-1:0] ab;
    logic [2*FRAC_W:0]   ab_r;
    logic [WT_W-1:0]     wval [NTAPS];

    // Weight arithmetic: rounded corner product, the rest by difference.
    always_comb begin
        ab      = frac_a * frac_b;
        ab_r    = {1'b0, ab} + (2*FRAC_W+1)'(HALF);
        wval[3] = ab_r[FRAC_W +: WT_W];
        wval[1] = {1'b0, frac_a} - wval[3];
        wval[2] = {1'b0, frac_b} - wval[3];
        wval[0] = WT_W'(ONE) - {1'b0, frac_a} - {1'b0, frac_b} + wval[3];
    end

    // One digit recoder per tap.
    for (genvar t = 0; t < NTAPS; t++) begin : g_code
        assign wt_code[t] = booth_code(wval[t]);
    end

endmodule

// File: rtl/bilerp_ctrl.sv
// Module: job sequencer. Accepts a start when no job is stepping, keeps the
// coded weights for the remaining steps, selects the weight of the current
// step and delays the first/last markers to the accumulate stage.
// Assumes the texel stream follows the start on consecutive cycles.
module bilerp_ctrl
    import bilerp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  bweight_t [NTAPS-1:0]  live_code,
    output bweight_t              cur_code,
    output logic                  iss_first,
    output logic                  acc_first,
    output logic                  acc_last
);

    localparam int STEP_W = $clog2(NTAPS);

    logic                 active;
    logic [STEP_W-1:0]    step;
    bweight_t [NTAPS-1:0] held;
    logic                 iss_last;
    logic [PIPE_D-1:0]    first_pipe;
    logic [PIPE_D-1:0]    last_pipe;

    // Issue decode: accept start only when idle; pick this step's weight.
    always_comb begin
        iss_first = rst_n && start && !active;
        iss_last  = active && (step == STEP_W'(NTAPS - 1));
        cur_code  = iss_first ? live_code[0] : held[step];
    end

    // Step counter and weight hold register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            step   <= '0;
            held   <= '0;
        end else if (iss_first) begin
            active <= 1'b1;
            step   <= STEP_W'(1);
            held   <= live_code;
        end else if (active) begin
            if (iss_last) active <= 1'b0;
            step <= step + STEP_W'(1);
        end
    end

    // Marker delay line matching the partial-product and carry-save stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_pipe <= '0;
            last_pipe  <= '0;
        end else begin
            first_pipe <= {first_pipe[PIPE_D-2:0], iss_first};
            last_pipe  <= {last_pipe[PIPE_D-2:0], iss_last};
        end
    end

    assign acc_first = first_pipe[PIPE_D-1];
    assign acc_last  = last_pipe[PIPE_D-1];

endmodule

// File: rtl/bilerp_lane.sv
// Module: one colour lane. Forms four shifted/negated partial products of the
// current texel, reduces them through two carry-save stages, and folds each
// texel's product into the accumulator; on the last texel it stores the
// rounded channel. Assumes four digits per weight (NDIG = 4).
module bilerp_lane
    import bilerp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_W-1:0]   texel,
    input  bweight_t          cur_code,
    input  logic              acc_first,
    input  logic              acc_last,
    output logic [CH_W-1:0]   chan_out
);

    logic signed [ACC_W-1:0] pp_c [NDIG];
    logic signed [ACC_W-1:0] r_q  [NDIG];
    logic signed [ACC_W-1:0] s1_q, c1_q, r3_q;
    logic signed [ACC_W-1:0] s2_q, c2_q;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] total;
    logic signed [ACC_W-1:0] rnd;

    // Partial-product selection, one per digit position.
    for (genvar j = 0; j < NDIG; j++) begin : g_pp
        assign pp_c[j] = pp_form(texel, cur_code[j], j);
    end

    // Accumulate value and its rounded form.
    always_comb begin
        total = (acc_first ? '0 : acc_q) + s2_q + c2_q;
        rnd   = total + ACC_W'(HALF);
    end

    // Partial-product registers, carry-save chain and accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < NDIG; j++) r_q[j] <= '0;
            s1_q     <= '0;
            c1_q     <= '0;
            r3_q     <= '0;
            s2_q     <= '0;
            c2_q     <= '0;
            acc_q    <= '0;
            chan_out <= '0;
        end else begin
            for (int j = 0; j < NDIG; j++) r_q[j] <= pp_c[j];
            s1_q  <= r_q[0] ^ r_q[1] ^ r_q[2];
            c1_q  <= ((r_q[0] & r_q[1]) | (r_q[0] & r_q[2]) | (r_q[1] & r_q[2])) <<< 1;
            r3_q  <= r_q[3];
            s2_q  <= s1_q ^ c1_q ^ r3_q;
            c2_q  <= ((s1_q & c1_q) | (s1_q & r3_q) | (c1_q & r3_q)) <<< 1;
            acc_q <= total;
            if (acc_last) chan_out <= rnd[FRAC_W +: CH_W];
        end
    end

endmodule

// File: rtl/bilerp_top.sv
// Module: bilinear texel filter top. Builds weights from the fractions,
// sequences four texels per job and runs one lane per colour channel.
// Assumes texels arrive on the start cycle and the three cycles after it.
module bilerp_top
    import bilerp_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [FRAC_W-1:0]       frac_a,
    input  logic [FRAC_W-1:0]       frac_b,
    input  logic [LANES*CH_W-1:0]   texel,
    output logic                    out_valid,
    output logic [LANES*CH_W-1:0]   out_pix
);

    bweight_t [NTAPS-1:0] live_code;
    bweight_t             cur_code;
    logic                 iss_first;
    logic                 acc_first;
    logic                 acc_last;

    bilerp_weights u_wts (
        .frac_a  (frac_a),
        .frac_b  (frac_b),
        .wt_code (live_code)
    );

    bilerp_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .live_code (live_code),
        .cur_code  (cur_code),
        .iss_first (iss_first),
        .acc_first (acc_first),
        .acc_last  (acc_last)
    );

    // One datapath per colour channel.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        bilerp_lane u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .texel     (texel[l*CH_W +: CH_W]),
            .cur_code  (cur_code),
            .acc_first (acc_first),
            .acc_last  (acc_last),
            .chan_out  (out_pix[l*CH_W +: CH_W])
        );
    end

    // Result strobe, aligned with the lane output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= acc_last;
    end

endmodule

// File: rtl/bilerp_chk.sv
// Module: property checker for bilerp_top, attached by bind below.
// Observes the coded weights at issue, the issue strobe and the outputs.
module bilerp_chk
    import bilerp_pkg::*;
#(
    parameter int PIX_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  iss_first,
    input  logic                  out_valid,
    input  bweight_t [NTAPS-1:0]  live_code,
    input  logic [PIX_W-1:0]      out_pix
);

    int   wsum;
    int   wv;
    logic form_ok;
    logic range_ok;

    // Decode the coded weights back to integers and check digit form.
    always_comb begin
        wsum     = 0;
        form_ok  = 1'b1;
        range_ok = 1'b1;
        for (int t = 0; t < NTAPS; t++) begin
            wv = 0;
            for (int k = 0; k < NDIG; k++) begin
                wv = wv + dig_val(live_code[t][k]) * (1 << (2 * k));
                if (live_code[t][k].one && live_code[t][k].two) form_ok = 1'b0;
                if (live_code[t][k].neg && !live_code[t][k].one && !live_code[t][k].two) form_ok = 1'b0;
            end
            if (wv < 0 || wv > ONE) range_ok = 1'b0;
            wsum = wsum + wv;
        end
    end

    a_r1_weight_sum: assert property (@(posedge clk) disable iff (!rst_n)
        iss_first |-> (wsum == ONE));

    a_r1_weight_range: assert property (@(posedge clk) disable iff (!rst_n)
        iss_first |-> range_ok);

    a_r2_digit_form: assert property (@(posedge clk) disable iff (!rst_n)
        iss_first |-> form_ok);

    a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        iss_first |-> (!$past(iss_first, 1) && !$past(iss_first, 2) && !$past(iss_first, 3)));

    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(iss_first, 7));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r8_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!$past(out_valid, 2) && !$past(out_valid, 3)));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_pix));

endmodule

bind bilerp_top bilerp_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_first (iss_first),
    .out_valid (out_valid),
    .live_code (live_code),
    .out_pix   (out_pix)
);

// File: tb/bilerp_top_tb.sv
// Directed bench for bilerp_top: one task per scenario, results compared
// with a reference built from the weight formula.
module bilerp_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 7;
    localparam int PW         = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [6:0]    frac_a = '0;
    logic [6:0]    frac_b = '0;
    logic [PW-1:0] texel = '0;
    logic          out_valid;
    logic [PW-1:0] out_pix;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    logic [PW-1:0] last_pix = '0;

    int            exp_cyc [$];
    logic [PW-1:0] exp_pix [$];
    string         exp_tag [$];

    bilerp_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .frac_a    (frac_a),
        .frac_b    (frac_b),
        .texel     (texel),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Reference per R1 and R6.
    function automatic logic [PW-1:0] ref_pix(input int a, input int b,
                                              input logic [PW-1:0] p0, input logic [PW-1:0] p1,
                                              input logic [PW-1:0] p2, input logic [PW-1:0] p3);
        int w11, w10, w01, w00, s;
        logic [PW-1:0] r;
        w11 = (a * b + 64) >> 7;
        w10 = a - w11;
        w01 = b - w11;
        w00 = 128 - a - b + w11;
        for (int l = 0; l < 4; l++) begin
            s = w00 * int'(p0[8*l +: 8]) + w10 * int'(p1[8*l +: 8])
              + w01 * int'(p2[8*l +: 8]) + w11 * int'(p3[8*l +: 8]);
            s = (s + 64) >> 7;
            r[8*l +: 8] = 8'(s);
        end
        return r;
    endfunction

    // Output monitor: R5 timing and value comparison.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
                    chk(out_pix == exp_pix[0], exp_tag[0], out_pix, exp_pix[0]);
                    last_pix = exp_pix[0];
                    void'(exp_cyc.pop_front());
                    void'(exp_pix.pop_front());
                    exp_tag.pop_front();
                end else begin
                    chk(1'b0, "R4 R5 unexpected result", out_pix, '0);
                end
            end
            if (exp_cyc.size() > 0 && exp_cyc[0] < cyc) begin
                chk(1'b0, {exp_tag[0], " R5 missing result"}, out_pix, exp_pix[0]);
                void'(exp_cyc.pop_front());
                void'(exp_pix.pop_front());
                exp_tag.pop_front();
            end
        end
    end

    // Issue one job from a falling edge; optionally keep start high (R4).
    task automatic issue(input int a, input int b,
                         input logic [PW-1:0] p0, input logic [PW-1:0] p1,
                         input logic [PW-1:0] p2, input logic [PW-1:0] p3,
                         input string tag, input bit hold_start);
        start  = 1'b1;
        frac_a = 7'(a);
        frac_b = 7'(b);
        texel  = p0;
        exp_cyc.push_back(cyc + LAT);
        exp_pix.push_back(ref_pix(a, b, p0, p1, p2, p3));
        exp_tag.push_back(tag);
        @(negedge clk);
        start  = hold_start;
        frac_a = 7'($urandom);
        frac_b = 7'($urandom);
        texel  = p1;
        @(negedge clk);
        texel  = p2;
        @(negedge clk);
        texel  = p3;
        @(negedge clk);
        start  = 1'b0;
        texel  = $urandom;
    endtask

    task automatic drain(input string tag);
        repeat (12) @(negedge clk);
        chk(exp_cyc.size() == 0, {tag, " R5 all results seen"}, 32'(exp_cyc.size()), '0);
    endtask

    task automatic test_reset();
        repeat (5) @(negedge clk);
        chk(out_valid == 1'b0, "R7 reset valid", {31'b0, out_valid}, '0);
        chk(out_pix == '0, "R7 reset pixel", out_pix, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 idle valid", {31'b0, out_valid}, '0);
        chk(out_pix == '0, "R7 idle pixel", out_pix, '0);
    endtask

    task automatic test_corners();
        issue(0, 0, 32'h11223344, 32'hffffffff, 32'h00000000, 32'h80808080, "R9 zero fractions", 1'b0);
        issue(127, 127, 32'h10203040, 32'h50607080, 32'h90a0b0c0, 32'hd0e0f0ff, "R1 max fractions", 1'b0);
        issue(127, 0, 32'h00ff00ff, 32'hff00ff00, 32'h12345678, 32'h9abcdef0, "R1 a max", 1'b0);
        issue(0, 127, 32'h01020304, 32'h05060708, 32'hfffefdfc, 32'h00000001, "R1 b max", 1'b0);
        issue(64, 64, 32'hff000000, 32'h00ff0000, 32'h0000ff00, 32'h000000ff, "R1 centre", 1'b0);
        drain("R3");
    endtask

    task automatic test_uniform();
        for (int i = 0; i < 4; i++) begin
            logic [PW-1:0] v;
            v = (i == 0) ? 32'hffffffff : $urandom;
            issue(int'($urandom_range(127)), int'($urandom_range(127)), v, v, v, v, "R9 uniform texels", 1'b0);
            chk(ref_pix(int'(frac_a), int'(frac_b), v, v, v, v) == v, "R9 reference identity", v, v);
        end
        drain("R9");
    endtask

    task automatic test_lanes();
        issue(37, 91, 32'hff00ff00, 32'h00ff00ff, 32'hff0000ff, 32'h00ffff00, "R6 lane extremes", 1'b0);
        issue(5, 120, 32'h000000ff, 32'h0000ff00, 32'h00ff0000, 32'hff000000, "R6 one-hot lanes", 1'b0);
        drain("R6");
    endtask

    task automatic test_random();
        for (int i = 0; i < 16; i++) begin
            issue(int'($urandom_range(127)), int'($urandom_range(127)),
                  $urandom, $urandom, $urandom, $urandom, "R3 R6 random job", 1'b0);
            repeat (int'($urandom_range(4))) @(negedge clk);
        end
        drain("R3");
    endtask

    task automatic test_back_to_back();
        for (int i = 0; i < 10; i++) begin
            issue(int'($urandom_range(127)), int'($urandom_range(127)),
                  $urandom, $urandom, $urandom, $urandom, "R8 back-to-back", 1'b0);
        end
        drain("R8");
    endtask

    task automatic test_ignored_start();
        issue(23, 101, 32'h13579bdf, 32'h2468ace0, 32'hfedcba98, 32'h01234567, "R4 start held", 1'b1);
        drain("R4");
        issue(99, 3, 32'h80402010, 32'h08040201, 32'hc0c0c0c0, 32'h3f3f3f3f, "R4 start held again", 1'b1);
        drain("R4");
    endtask

    task automatic test_hold();
        repeat (6) @(negedge clk);
        chk(out_valid == 1'b0, "R7 hold valid", {31'b0, out_valid}, '0);
        chk(out_pix == last_pix, "R7 hold pixel", out_pix, last_pix);
    endtask

    initial begin
        test_reset();
        test_corners();
        test_uniform();
        test_lanes();
        test_random();
        test_back_to_back();
        test_ignored_start();
        test_hold();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R5 actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule